// File: doc/BRIEF.md
# RTC Time Snapshot Sequencer

This block sits on top of a bit-serial access engine for an external real-time clock and turns single-register frames into whole-time operations. After reset it first clocks out a run of single-bit dummy reads so that the clock chip is aligned to the start of a frame. It then writes a test byte to the seconds register, reads it back, and clears the chip's status register. Only after all of that has passed does it report itself ready. If the test byte does not come back, it flags the device as absent and stays silent from then on.

A read request first sends a command frame that freezes the running clock into the chip's holding registers. It then reads the seven time fields one after another and converts each packed-BCD byte to binary. A set request converts seven binary fields to packed BCD, writes them, and finishes with a command frame that copies the holding registers into the running clock. Every frame goes to the engine as a request carrying an operation code, an address and write data. The request is held until the engine answers with done.

Top module: `rtc_snapshot_seq`

## Requirements
- R1: After reset the first engine requests are exactly WAKE_BITS (default 8) single-bit reads (eng_op 0), before any other frame.
- R2: The start-up check then writes 0x33 to the seconds address (eng_op 2, address 2), reads that address back (eng_op 1), and on a match writes 0x00 to the status address (address 0). ready rises only after this and no other frame is issued during start-up.
- R3: If the read-back byte is not 0x33, dev_absent goes high and stays high, ready stays low, and no further engine request is issued, even when rd_req or set_req is pulsed.
- R4: A read issues one command frame (eng_op 3) with the snapshot code 0xE, then seven read frames at addresses 2,3,4,5,6,7,8 (seconds, minutes, hours, day of month, month, day of week, year) in that order.
- R5: When a read completes, rd_valid pulses for one cycle and get_time holds the seven fields in binary, 7 bits each, seconds in bits 6:0 and then upward in the order of R4. Each field is the decimal value of its BCD byte, except that month is one less than the stored value.
- R6: A set issues seven write frames (eng_op 2) at addresses 2 to 8 in the order of R4, carrying the packed-BCD form of the fields of set_time (same layout as get_time). Month is written as its value plus one and year as its value modulo 100. A command frame with the commit code 0xF follows, and then set_done pulses for one cycle.
- R7: fmt_err is cleared when a read starts and goes high if any byte read during that time read has a nibble above 9.
- R8: ready is high only while idle after a passing start-up. rd_req and set_req are sampled only while ready, so pulses during a read or set have no effect. When both are high together, the read is performed and the set is dropped.
- R9: eng_req, eng_op, eng_addr and eng_wdata stay unchanged from the rise of eng_req until the cycle with eng_done. eng_req falls in the cycle after eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Start a time read (sampled while ready) |
| set_req | input | 1 | Start a time set (sampled while ready) |
| set_time | input | 49 | Seven binary fields to write, 7 bits each |
| get_time | output | 49 | Seven binary fields last read, 7 bits each |
| rd_valid | output | 1 | One-cycle pulse: read finished |
| set_done | output | 1 | One-cycle pulse: set committed |
| ready | output | 1 | Idle and start-up passed |
| dev_absent | output | 1 | Start-up read-back failed |
| fmt_err | output | 1 | Last time read contained a non-decimal nibble |
| eng_req | output | 1 | Frame request to the serial engine |
| eng_op | output | 2 | 0 bit read, 1 read frame, 2 write frame, 3 command frame |
| eng_addr | output | 4 | Register address or command code |
| eng_wdata | output | 8 | Byte for a write frame |
| eng_done | input | 1 | Engine finished the current frame |
| eng_rdata | input | 8 | Byte returned by a read frame |

## Verification
The hardest state to reach from the ports is the dead state after a failed start-up check. It exists only when the clock chip does not echo the probe byte. The bench's engine model has an absent mode in which every read returns zero. The bench resets the block with that mode on and then shows that later requests produce no frames at all. Non-decimal nibbles are equally unreachable with a healthy clock, so the bench loads a corrupt minutes byte straight into the model's running clock before a snapshot.

// File: rtl/rtc_snapshot_seq.sv
module rtc_snapshot_seq #(
  parameter int unsigned WAKE_BITS  = 8,
  parameter logic [7:0]  PROBE      = 8'h33,
  parameter logic [3:0]  A_STATUS   = 4'd0,
  parameter logic [3:0]  A_SEC      = 4'd2,
  parameter logic [3:0]  A_MIN      = 4'd3,
  parameter logic [3:0]  A_HOUR     = 4'd4,
  parameter logic [3:0]  A_MDAY     = 4'd5,
  parameter logic [3:0]  A_MON      = 4'd6,
  parameter logic [3:0]  A_WDAY     = 4'd7,
  parameter logic [3:0]  A_YEAR     = 4'd8,
  parameter logic [3:0]  CMD_SNAP   = 4'hE,
  parameter logic [3:0]  CMD_COMMIT = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        set_req,
  input  logic [48:0] set_time,
  output logic [48:0] get_time,
  output logic        rd_valid,
  output logic        set_done,
  output logic        ready,
  output logic        dev_absent,
  output logic        fmt_err,
  output logic        eng_req,
  output logic [1:0]  eng_op,
  output logic [3:0]  eng_addr,
  output logic [7:0]  eng_wdata,
  input  logic        eng_done,
  input  logic [7:0]  eng_rdata
);
  localparam int NF = 7;
  localparam int FW = 7;
  localparam int MON_IX = 4;
  localparam int YEAR_IX = 6;
  localparam logic [1:0] OP_BIT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_CMD = 2'd3;
  localparam logic [3:0] FADDR [NF] = '{A_SEC, A_MIN, A_HOUR, A_MDAY, A_MON, A_WDAY, A_YEAR};
  localparam logic [3:0] WAKE_LAST = 4'(WAKE_BITS - 1);
  localparam logic [3:0] F_LAST = 4'(NF - 1);

  typedef enum logic [3:0] {S_WAKE, S_PW, S_PR, S_STAT, S_IDLE, S_SNAP, S_RD, S_WR, S_CMT, S_DEAD} st_t;

  st_t st;
  logic [3:0]    cnt;
  logic [7:0]    raw [NF];
  logic [48:0]   set_q;
  logic [1:0]    op_n;
  logic [3:0]    addr_n;
  logic [7:0]    wd_n;
  logic [FW-1:0] fv, fadj;

  function automatic logic [FW-1:0] bcd2bin(input logic [7:0] b);
    return FW'({3'd0, b[7:4]} * 7'd10 + {3'd0, b[3:0]});
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [FW-1:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic bad_bcd(input logic [7:0] b);
    return (b[7:4] > 4'd9) || (b[3:0] > 4'd9);
  endfunction

  assign fv = set_q[FW*cnt[2:0] +: FW];
  assign fadj = (cnt == 4'(MON_IX)) ? fv + 7'd1 :
                (cnt == 4'(YEAR_IX)) ? FW'(fv % 7'd100) : fv;

  always_comb begin
    op_n = OP_BIT; addr_n = '0; wd_n = '0;
    case (st)
      S_PW:   begin op_n = OP_WR;  addr_n = A_SEC;    wd_n = PROBE; end
      S_PR:   begin op_n = OP_RD;  addr_n = A_SEC; end
      S_STAT: begin op_n = OP_WR;  addr_n = A_STATUS; end
      S_SNAP: begin op_n = OP_CMD; addr_n = CMD_SNAP; end
      S_RD:   begin op_n = OP_RD;  addr_n = FADDR[cnt[2:0]]; end
      S_WR:   begin op_n = OP_WR;  addr_n = FADDR[cnt[2:0]]; wd_n = bin2bcd(fadj); end
      S_CMT:  begin op_n = OP_CMD; addr_n = CMD_COMMIT; end
      default: ;
    endcase
  end

  assign ready = (st == S_IDLE);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    if (i == MON_IX) begin : g_mon
      assign get_time[FW*i +: FW] = bcd2bin(raw[i]) - 7'd1;
    end else begin : g_plain
      assign get_time[FW*i +: FW] = bcd2bin(raw[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAKE; cnt <= '0; set_q <= '0;
      rd_valid <= 1'b0; set_done <= 1'b0; dev_absent <= 1'b0; fmt_err <= 1'b0;
      eng_req <= 1'b0; eng_op <= OP_BIT; eng_addr <= '0; eng_wdata <= '0;
      for (int i = 0; i < NF; i++) raw[i] <= '0;
    end else begin
      rd_valid <= 1'b0;
      set_done <= 1'b0;
      if (eng_req) begin
        if (eng_done) begin
          eng_req <= 1'b0;
          case (st)
            S_WAKE: if (cnt == WAKE_LAST) begin st <= S_PW; cnt <= '0; end
                    else cnt <= cnt + 4'd1;
            S_PW:   st <= S_PR;
            S_PR:   if (eng_rdata == PROBE) st <= S_STAT;
                    else begin st <= S_DEAD; dev_absent <= 1'b1; end
            S_STAT: st <= S_IDLE;
            S_SNAP: begin st <= S_RD; cnt <= '0; end
            S_RD: begin
              raw[cnt[2:0]] <= eng_rdata;
              if (bad_bcd(eng_rdata)) fmt_err <= 1'b1;
              if (cnt == F_LAST) begin st <= S_IDLE; rd_valid <= 1'b1; end
              else cnt <= cnt + 4'd1;
            end
            S_WR:   if (cnt == F_LAST) st <= S_CMT;
                    else cnt <= cnt + 4'd1;
            S_CMT:  begin st <= S_IDLE; set_done <= 1'b1; end
            default: ;
          endcase
        end
      end else begin
        case (st)
          S_IDLE:
            if (rd_req) begin st <= S_SNAP; fmt_err <= 1'b0; end
            else if (set_req) begin st <= S_WR; cnt <= '0; set_q <= set_time; end
          S_DEAD: ;
          default: begin
            eng_req <= 1'b1; eng_op <= op_n; eng_addr <= addr_n; eng_wdata <= wd_n;
          end
        endcase
      end
    end
  end
endmodule

module rtc_snapshot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_req,
  input logic       eng_done,
  input logic [1:0] eng_op,
  input logic [3:0] eng_addr,
  input logic [7:0] eng_wdata,
  input logic       ready,
  input logic       dev_absent,
  input logic       rd_valid,
  input logic       set_done
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_addr) && $stable(eng_wdata));
  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done |=> !eng_req);
  p_absent_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_absent |-> !eng_req && !ready);
  p_absent_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_absent |=> dev_absent);
  p_ready_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !eng_req);
  p_rdvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_setdone_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> !set_done);
endmodule

bind rtc_snapshot_seq rtc_snapshot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_done(eng_done),
  .eng_op(eng_op), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
  .ready(ready), .dev_absent(dev_absent), .rd_valid(rd_valid), .set_done(set_done)
);

// File: tb/rtc_snapshot_seq_tb.sv
`timescale 1ns/1ps
module rtc_snapshot_seq_tb;
  localparam logic [1:0] OP_BIT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_CMD = 2'd3;
  localparam int NV = 3;
  localparam logic [55:0] V_BCD [NV] = '{
    {8'h99, 8'h06, 8'h12, 8'h31, 8'h23, 8'h30, 8'h59},
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00},
    {8'h24, 8'h03, 8'h06, 8'h15, 8'h12, 8'h45, 8'h07}};
  localparam logic [48:0] V_EXP [NV] = '{
    {7'd99, 7'd6, 7'd11, 7'd31, 7'd23, 7'd30, 7'd59},
    {7'd0,  7'd0, 7'd0,  7'd1,  7'd0,  7'd0,  7'd0},
    {7'd24, 7'd3, 7'd5,  7'd15, 7'd12, 7'd45, 7'd7}};

  logic clk = 0, rst_n = 0, rd_req = 0, set_req = 0;
  logic [48:0] set_time = '0, get_time;
  logic rd_valid, set_done, ready, dev_absent, fmt_err, eng_req;
  logic [1:0] eng_op;
  logic [3:0] eng_addr;
  logic [7:0] eng_wdata;
  logic eng_done = 0;
  logic [7:0] eng_rdata = '0;

  logic absent = 0, load_en = 0;
  logic [55:0] load_val = '0;
  logic [7:0] ram [16];
  logic [7:0] clkr [16];
  logic [1:0] log_op [256];
  logic [3:0] log_ad [256];
  logic [7:0] log_wd [256];
  int log_n = 0, ecnt = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_snapshot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .set_req(set_req), .set_time(set_time),
    .get_time(get_time), .rd_valid(rd_valid), .set_done(set_done), .ready(ready),
    .dev_absent(dev_absent), .fmt_err(fmt_err), .eng_req(eng_req), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata));

  always @(posedge clk) begin
    if (load_en) for (int k = 0; k < 7; k++) clkr[k+2] <= load_val[8*k +: 8];
    if (!rst_n) begin
      eng_done <= 0; ecnt <= 0;
    end else begin
      eng_done <= 0;
      if (eng_req && !eng_done) begin
        if (ecnt == 2) begin
          ecnt <= 0; eng_done <= 1;
          if (log_n < 256) begin
            log_op[log_n] <= eng_op; log_ad[log_n] <= eng_addr; log_wd[log_n] <= eng_wdata;
          end
          log_n <= log_n + 1;
          case (eng_op)
            OP_BIT: eng_rdata <= absent ? 8'h00 : 8'h01;
            OP_RD:  eng_rdata <= absent ? 8'h00 : ram[eng_addr];
            OP_WR:  ram[eng_addr] <= eng_wdata;
            default: begin
              if (eng_addr == 4'hE) for (int k = 2; k <= 8; k++) ram[k] <= clkr[k];
              if (eng_addr == 4'hF) for (int k = 2; k <= 8; k++) clkr[k] <= ram[k];
            end
          endcase
        end else ecnt <= ecnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ready) begin ok = 1; break; end
    end
  endtask

  task automatic load(input logic [55:0] v);
    @(negedge clk); load_val = v; load_en = 1;
    @(negedge clk); load_en = 0;
  endtask

  task automatic do_read(input bit with_set, output bit seen);
    seen = 0;
    @(negedge clk); rd_req = 1; set_req = with_set;
    @(negedge clk); rd_req = 0; set_req = 0;
    for (int i = 0; i < 2000; i++) begin
      if (rd_valid) begin seen = 1; break; end
      if (i == 3) set_req = 1;
      if (i == 4) set_req = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int base, nwr;
    for (int k = 0; k < 16; k++) begin ram[k] = 8'h00; clkr[k] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(!ready && !eng_req && !dev_absent && !rd_valid && !set_done, "R2 reset state",
        {ready, eng_req, dev_absent, rd_valid, set_done}, 0);
    do_reset();
    wait_ready(ok);
    chk(ok, "R2 ready after start-up", ok, 1);
    chk(log_n == 11, "R2 start-up frame count", log_n, 11);
    ok = 1;
    for (int i = 0; i < 8; i++) if (log_op[i] != OP_BIT) ok = 0;
    chk(ok, "R1 eight dummy bit reads first", log_op[0], OP_BIT);
    chk(log_op[8] == OP_WR && log_ad[8] == 4'd2 && log_wd[8] == 8'h33, "R2 probe write",
        {log_op[8], log_ad[8], log_wd[8]}, {OP_WR, 4'd2, 8'h33});
    chk(log_op[9] == OP_RD && log_ad[9] == 4'd2, "R2 probe read", {log_op[9], log_ad[9]}, {OP_RD, 4'd2});
    chk(log_op[10] == OP_WR && log_ad[10] == 4'd0 && log_wd[10] == 8'h00, "R2 status clear",
        {log_op[10], log_ad[10], log_wd[10]}, {OP_WR, 4'd0, 8'h00});

    for (int v = 0; v < NV; v++) begin
      load(V_BCD[v]);
      base = log_n;
      do_read(0, ok);
      chk(ok, "R5 rd_valid seen", ok, 1);
      chk(get_time == V_EXP[v], "R5 converted time", get_time, V_EXP[v]);
      chk(!fmt_err, "R7 clean read", fmt_err, 0);
      ok = (log_n - base == 8) && log_op[base] == OP_CMD && log_ad[base] == 4'hE;
      for (int f = 0; f < 7; f++)
        if (log_op[base+1+f] != OP_RD || log_ad[base+1+f] != 4'(f + 2)) ok = 0;
      chk(ok, "R4 snapshot then ordered reads", log_n - base, 8);
    end

    set_time = {7'd123, 7'd2, 7'd0, 7'd28, 7'd9, 7'd7, 7'd45};
    base = log_n;
    @(negedge clk); set_req = 1;
    @(negedge clk); set_req = 0;
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      if (set_done) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok, "R6 set_done seen", ok, 1);
    begin
      logic [7:0] ew [7] = '{8'h45, 8'h07, 8'h09, 8'h28, 8'h01, 8'h02, 8'h23};
      for (int f = 0; f < 7; f++)
        chk(log_op[base+f] == OP_WR && log_ad[base+f] == 4'(f + 2) && log_wd[base+f] == ew[f],
            "R6 field write", {log_op[base+f], log_ad[base+f], log_wd[base+f]}, {OP_WR, 4'(f + 2), ew[f]});
    end
    chk(log_op[base+7] == OP_CMD && log_ad[base+7] == 4'hF && log_n - base == 8, "R6 commit last",
        {log_op[base+7], log_ad[base+7]}, {OP_CMD, 4'hF});
    do_read(0, ok);
    chk(get_time == {7'd23, 7'd2, 7'd0, 7'd28, 7'd9, 7'd7, 7'd45}, "R6 readback after commit",
        get_time, {7'd23, 7'd2, 7'd0, 7'd28, 7'd9, 7'd7, 7'd45});

    base = log_n;
    do_read(1, ok);
    repeat (30) @(negedge clk);
    nwr = 0;
    for (int i = base; i < log_n; i++) if (log_op[i] == OP_WR) nwr++;
    chk(log_op[base] == OP_CMD && log_ad[base] == 4'hE, "R8 read wins over set", log_ad[base], 4'hE);
    chk(nwr == 0 && log_n - base == 8 && ready, "R8 set ignored while busy", nwr, 0);

    load({8'h24, 8'h03, 8'h06, 8'h15, 8'h12, 8'h7A, 8'h07});
    do_read(0, ok);
    chk(fmt_err, "R7 bad nibble flagged", fmt_err, 1);
    load(V_BCD[0]);
    do_read(0, ok);
    chk(!fmt_err, "R7 flag cleared on next read", fmt_err, 0);

    @(negedge clk); absent = 1;
    base = log_n;
    do_reset();
    repeat (300) @(negedge clk);
    chk(dev_absent && !ready, "R3 absent flagged", {dev_absent, ready}, 2'b10);
    chk(log_n - base == 10, "R3 halt after probe", log_n - base, 10);
    @(negedge clk); rd_req = 1; set_req = 1;
    @(negedge clk); rd_req = 0; set_req = 0;
    repeat (50) @(negedge clk);
    chk(log_n - base == 10 && dev_absent && !eng_req, "R3 requests ignored when absent", log_n - base, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule